// File: doc/BRIEF.md
# Cycle-by-Cycle Overcurrent Gate Limiter

This block is a synchronous protection stage. It sits between a PWM source and the enable of a gate driver. Each clock it takes a registered PWM level, a sampled current-sense value, a limit code and two supply samples, all in millivolts. It drives a gated PWM output and a latched fault flag that a host polls.

When the sensed value comes within a fixed offset of the effective limit, the output is cut for the rest of that pulse and the flag is set. The flag stays set until the next PWM rising edge that arrives with no fault present. The flag also serves as a power-up handshake. It stays high while either supply is outside its window, and it drops once both supplies are good, which tells the host that pulses will now be processed.

Both supply monitors use hysteresis. The limit code is clamped at an upper bound. A default limit applies when the limit input is reported as not driven.

Top module: `ocl_limiter`

## Requirements
- R1: A trip is present in a cycle when sense_mv + 25 > T (unsigned), where T is the effective threshold; any T below 25 therefore trips for every sense value.
- R2: A trip sampled at a clock edge makes limit_flag 1 and gate_out 0 after that edge, and gate_out stays 0 for the remainder of that PWM high pulse even after the trip condition goes away.
- R3: A set flag clears only at an edge where pwm_in is 1, the previous sample of pwm_in was 0, and no trip is present; a rising edge that arrives while a trip is present leaves the flag at 1.
- R4: While limit_flag is 0 and both supplies are good, gate_out equals pwm_in as it was at the previous clock edge (one cycle of latency).
- R5: With limit_open = 0, T is the smaller of limit_mv and 1000.
- R6: With limit_open = 1, T is 500 regardless of limit_mv.
- R7: The main supply monitor becomes good when vmain_mv >= 4500 and becomes not good when vmain_mv < 4250; between these values it keeps its previous state.
- R8: The auxiliary rail monitor becomes good when vaux_mv >= 3000 and becomes not good when vaux_mv < 2800; between these values it keeps its previous state.
- R9: In any cycle in which a monitor reads not good, gate_out is 0, and limit_flag is 1 from the following cycle on.
- R10: In the first cycle in which both monitors read good, the flag clears at the next edge if no trip is present; if a trip is present the flag stays set until a PWM rising edge as in R3.
- R11: Synchronous reset makes limit_flag 1 and gate_out 0, with both monitors not good.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwm_in | input | 1 | PWM level from the controller |
| sense_mv | input | 13 | Sampled current-sense value, mV |
| limit_mv | input | 13 | Requested limit threshold, mV |
| limit_open | input | 1 | 1 when the limit input is not driven |
| vmain_mv | input | 13 | Sampled main supply, mV |
| vaux_mv | input | 13 | Sampled 3.3 V rail, mV |
| gate_out | output | 1 | Gated PWM to the power stage |
| limit_flag | output | 1 | Latched limit / not-ready flag |

## Verification
The limit comparison is driven with sense values one millivolt either side of the trip point for an in-range limit, for a limit above the clamp, for the open-input default and for a limit below the offset, so that an error in the offset, the clamp or the default shows up as a flipped flag. Faults are applied mid-pulse, held across a PWM rising edge, and removed before an edge. This separates "cut for the rest of the pulse", "release on a clean edge" and "hold while the fault persists". The supplies are stepped through values inside each hysteresis band from both sides, so a monitor without memory or with swapped levels gives the wrong gate state. A long random phase with mixed pulse widths, limits and sense values is compared cycle by cycle against a bench model.

// File: rtl/ocl_pkg.sv
package ocl_pkg;
    localparam int MV_W = 13;
    typedef logic [MV_W-1:0] mv_t;

    typedef struct packed {
        logic main_ok;
        logic aux_ok;
    } rails_t;

    function automatic mv_t pick_threshold(input mv_t req, input logic open,
                                           input mv_t ceiling, input mv_t dflt);
        if (open)
            return dflt;
        return (req > ceiling) ? ceiling : req;
    endfunction
endpackage

// File: rtl/ocl_thresh.sv
module ocl_thresh
    import ocl_pkg::*;
#(
    parameter int OFFSET_MV  = 25,
    parameter int CEILING_MV = 1000,
    parameter int DEFAULT_MV = 500
) (
    input  mv_t  sense_mv,
    input  mv_t  limit_mv,
    input  logic limit_open,
    output logic trip
);
    localparam int EXT_W = MV_W + 1;
    localparam logic [EXT_W-1:0] OFFS = EXT_W'(OFFSET_MV);

    mv_t              thr;
    logic [EXT_W-1:0] lhs;

    always_comb begin
        thr  = pick_threshold(limit_mv, limit_open, mv_t'(CEILING_MV), mv_t'(DEFAULT_MV));
        lhs  = {1'b0, sense_mv} + OFFS;
        trip = lhs > {1'b0, thr};
    end
endmodule

// File: rtl/ocl_rail_mon.sv
module ocl_rail_mon
    import ocl_pkg::*;
#(
    parameter int RISE_MV = 4500,
    parameter int FALL_MV = 4250
) (
    input  logic clk,
    input  logic rst,
    input  mv_t  level_mv,
    output logic good
);
    localparam mv_t RISE = mv_t'(RISE_MV);
    localparam mv_t FALL = mv_t'(FALL_MV);

    always_ff @(posedge clk) begin
        if (rst)
            good <= 1'b0;
        else if (good)
            good <= (level_mv >= FALL);
        else
            good <= (level_mv >= RISE);
    end
endmodule

// File: rtl/ocl_flag.sv
module ocl_flag
    import ocl_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   pwm_in,
    input  logic   trip,
    input  rails_t rails,
    output logic   pwm_q,
    output logic   rails_seen,
    output logic   flag
);
    logic rails_ok;
    logic pwm_rise;
    logic rails_rise;

    always_comb begin
        rails_ok   = rails.main_ok & rails.aux_ok;
        pwm_rise   = pwm_in & ~pwm_q;
        rails_rise = rails_ok & ~rails_seen;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pwm_q      <= 1'b0;
            rails_seen <= 1'b0;
            flag       <= 1'b1;
        end else begin
            pwm_q      <= pwm_in;
            rails_seen <= rails_ok;
            if (!rails_ok || trip)
                flag <= 1'b1;
            else if (rails_rise || pwm_rise)
                flag <= 1'b0;
        end
    end
endmodule

// File: rtl/ocl_limiter.sv
module ocl_limiter
    import ocl_pkg::*;
#(
    parameter int OFFSET_MV    = 25,
    parameter int CEILING_MV   = 1000,
    parameter int DEFAULT_MV   = 500,
    parameter int MAIN_RISE_MV = 4500,
    parameter int MAIN_FALL_MV = 4250,
    parameter int AUX_RISE_MV  = 3000,
    parameter int AUX_FALL_MV  = 2800
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            pwm_in,
    input  logic [MV_W-1:0] sense_mv,
    input  logic [MV_W-1:0] limit_mv,
    input  logic            limit_open,
    input  logic [MV_W-1:0] vmain_mv,
    input  logic [MV_W-1:0] vaux_mv,
    output logic            gate_out,
    output logic            limit_flag
);
    logic   trip;
    rails_t rails;
    logic   pwm_q;
    logic   rails_seen;
    logic   rails_ok;

    ocl_thresh #(
        .OFFSET_MV (OFFSET_MV),
        .CEILING_MV(CEILING_MV),
        .DEFAULT_MV(DEFAULT_MV)
    ) u_thresh (
        .sense_mv  (sense_mv),
        .limit_mv  (limit_mv),
        .limit_open(limit_open),
        .trip      (trip)
    );

    ocl_rail_mon #(.RISE_MV(MAIN_RISE_MV), .FALL_MV(MAIN_FALL_MV)) u_main (
        .clk(clk), .rst(rst), .level_mv(vmain_mv), .good(rails.main_ok)
    );

    ocl_rail_mon #(.RISE_MV(AUX_RISE_MV), .FALL_MV(AUX_FALL_MV)) u_aux (
        .clk(clk), .rst(rst), .level_mv(vaux_mv), .good(rails.aux_ok)
    );

    ocl_flag u_flag (
        .clk       (clk),
        .rst       (rst),
        .pwm_in    (pwm_in),
        .trip      (trip),
        .rails     (rails),
        .pwm_q     (pwm_q),
        .rails_seen(rails_seen),
        .flag      (limit_flag)
    );

    always_comb begin
        rails_ok = rails.main_ok & rails.aux_ok;
        gate_out = pwm_q & ~limit_flag & rails_ok;
    end
endmodule

// File: rtl/ocl_limiter_chk.sv
module ocl_limiter_chk
    import ocl_pkg::*;
(
    input logic clk,
    input logic rst,
    input logic pwm_in,
    input logic trip,
    input logic main_ok,
    input logic aux_ok,
    input logic rails_seen,
    input mv_t  vmain_mv,
    input mv_t  vaux_mv,
    input logic gate_out,
    input logic limit_flag
);
    assert_trip_sets_flag_R2: assert property (@(posedge clk) disable iff (rst)
        trip |=> (limit_flag && !gate_out));

    assert_flag_holds_R3: assert property (@(posedge clk) disable iff (rst)
        (limit_flag && !pwm_in && rails_seen) |=> limit_flag);

    assert_follow_R4: assert property (@(posedge clk) disable iff (rst)
        (!limit_flag && main_ok && aux_ok) |-> (gate_out == $past(pwm_in)));

    assert_main_keep_R7: assert property (@(posedge clk) disable iff (rst)
        (main_ok && vmain_mv >= 13'd4250) |=> main_ok);

    assert_main_wait_R7: assert property (@(posedge clk) disable iff (rst)
        (!main_ok && vmain_mv < 13'd4500) |=> !main_ok);

    assert_aux_keep_R8: assert property (@(posedge clk) disable iff (rst)
        (aux_ok && vaux_mv >= 13'd2800) |=> aux_ok);

    assert_aux_wait_R8: assert property (@(posedge clk) disable iff (rst)
        (!aux_ok && vaux_mv < 13'd3000) |=> !aux_ok);

    assert_rail_gate_R9: assert property (@(posedge clk) disable iff (rst)
        !(main_ok && aux_ok) |-> !gate_out);

    assert_rail_flag_R9: assert property (@(posedge clk) disable iff (rst)
        !(main_ok && aux_ok) |=> limit_flag);
endmodule

bind ocl_limiter ocl_limiter_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .pwm_in    (pwm_in),
    .trip      (trip),
    .main_ok   (rails.main_ok),
    .aux_ok    (rails.aux_ok),
    .rails_seen(rails_seen),
    .vmain_mv  (vmain_mv),
    .vaux_mv   (vaux_mv),
    .gate_out  (gate_out),
    .limit_flag(limit_flag)
);

// File: tb/ocl_limiter_test.sv
module ocl_limiter_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pwm_in = 1'b0;
    logic [12:0] sense_mv = '0;
    logic [12:0] limit_mv = 13'd800;
    logic        limit_open = 1'b0;
    logic [12:0] vmain_mv = '0;
    logic [12:0] vaux_mv = '0;
    logic        gate_out;
    logic        limit_flag;

    int  n_run  = 0;
    int  n_fail = 0;
    bit  done   = 0;

    // bench model state
    bit m_flag = 1, m_pwmq = 0, m_main = 0, m_aux = 0, m_seen = 0;

    always #2.5 clk = ~clk;

    ocl_limiter uut (
        .clk(clk), .rst(rst), .pwm_in(pwm_in), .sense_mv(sense_mv),
        .limit_mv(limit_mv), .limit_open(limit_open), .vmain_mv(vmain_mv),
        .vaux_mv(vaux_mv), .gate_out(gate_out), .limit_flag(limit_flag)
    );

    function automatic bit exp_trip(int s, int l, bit open);
        int t;
        t = open ? 500 : ((l > 1000) ? 1000 : l);
        return (s + 25) > t;
    endfunction

    function automatic bit hyst(bit g, int v, int rise, int fall);
        return g ? (v >= fall) : (v >= rise);
    endfunction

    task automatic model_edge();
        bit ok, tr, nf;
        ok = m_main && m_aux;
        tr = exp_trip(sense_mv, limit_mv, limit_open);
        nf = m_flag;
        if (!ok || tr) nf = 1;
        else if ((ok && !m_seen) || (pwm_in && !m_pwmq)) nf = 0;
        m_flag = nf;
        m_seen = ok;
        m_pwmq = pwm_in;
        m_main = hyst(m_main, vmain_mv, 4500, 4250);
        m_aux  = hyst(m_aux, vaux_mv, 3000, 2800);
    endtask

    task automatic chk(string tag, bit got, bit exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0b expected %0b at %0t", tag, got, exp, $time);
        end
    endtask

    // one clock: model follows the edge, outputs compared at the falling edge
    task automatic step(string tag);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        chk({tag, " gate"}, gate_out, m_flag ? 1'b0 : (m_pwmq & m_main & m_aux));
        chk({tag, " flag"}, limit_flag, m_flag);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got hang expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        // R11: reset state
        chk("R11 flag", limit_flag, 1'b1);
        chk("R11 gate", gate_out, 1'b0);
        rst = 1'b0;
        m_flag = 1; m_pwmq = 0; m_main = 0; m_aux = 0; m_seen = 0;
        step("R11");

        // R10: supplies come up, flag releases
        vmain_mv = 13'd5000; vaux_mv = 13'd3300;
        step("R10"); step("R10"); step("R10");
        chk("R10 released", limit_flag, 1'b0);

        // R4: output follows with one cycle latency
        pwm_in = 1; step("R4");
        chk("R4 high", gate_out, 1'b1);
        step("R4");
        // R2: trip mid-pulse (limit 800, 776+25 > 800)
        sense_mv = 13'd776; step("R2");
        chk("R2 cut", gate_out, 1'b0);
        chk("R2 flag", limit_flag, 1'b1);
        sense_mv = 13'd0; step("R2"); step("R2");
        chk("R2 rest of pulse", gate_out, 1'b0);
        // R3: release on next clean rising edge
        pwm_in = 0; step("R3");
        pwm_in = 1; step("R3");
        chk("R3 release", limit_flag, 1'b0);
        chk("R3 gate on", gate_out, 1'b1);
        // R1: boundary just below trip
        sense_mv = 13'd775; step("R1");
        chk("R1 no trip", limit_flag, 1'b0);
        // R3: fault persists across edge
        sense_mv = 13'd900; pwm_in = 0; step("R3");
        pwm_in = 1; step("R3");
        chk("R3 held", limit_flag, 1'b1);
        sense_mv = 0; pwm_in = 0; step("R3"); pwm_in = 1; step("R3");
        // R5: clamp at 1000
        limit_mv = 13'd3000; sense_mv = 13'd975; step("R5");
        chk("R5 below clamp", limit_flag, 1'b0);
        sense_mv = 13'd976; step("R5");
        chk("R5 at clamp", limit_flag, 1'b1);
        sense_mv = 0; pwm_in = 0; step("R5"); pwm_in = 1; step("R5");
        // R6: default when open
        limit_open = 1; sense_mv = 13'd475; step("R6");
        chk("R6 below default", limit_flag, 1'b0);
        sense_mv = 13'd476; step("R6");
        chk("R6 at default", limit_flag, 1'b1);
        limit_open = 0; limit_mv = 13'd800; sense_mv = 0;
        pwm_in = 0; step("R6"); pwm_in = 1; step("R6");
        // R1: limit below offset always trips
        limit_mv = 13'd10; step("R1");
        chk("R1 tiny limit", limit_flag, 1'b1);
        limit_mv = 13'd800; pwm_in = 0; step("R1"); pwm_in = 1; step("R1");

        // R7: main hysteresis
        vmain_mv = 13'd4300; step("R7"); step("R7");
        chk("R7 stays good", gate_out, 1'b1);
        vmain_mv = 13'd4249; step("R7");
        chk("R7 drop gate", gate_out, 1'b0);
        step("R9");
        chk("R9 flag", limit_flag, 1'b1);
        vmain_mv = 13'd4400; step("R7"); step("R7");
        chk("R7 stays bad", limit_flag, 1'b1);
        vmain_mv = 13'd4500; step("R7"); step("R10"); step("R10");
        chk("R10 re-ready", limit_flag, 1'b0);
        // R8: aux hysteresis
        vaux_mv = 13'd2850; step("R8"); step("R8");
        chk("R8 stays good", gate_out, 1'b1);
        vaux_mv = 13'd2799; step("R8"); step("R8");
        chk("R8 bad", gate_out, 1'b0);
        vaux_mv = 13'd2950; step("R8"); step("R8");
        chk("R8 stays bad", limit_flag, 1'b1);
        vaux_mv = 13'd3000; step("R8");
        // R10: trip present at start-up keeps flag
        sense_mv = 13'd900; step("R10"); step("R10");
        chk("R10 trip at start", limit_flag, 1'b1);
        sense_mv = 0; pwm_in = 0; step("R10"); pwm_in = 1; step("R10");
        chk("R10 pulse clears", limit_flag, 1'b0);

        // random phase against the model
        void'($urandom(32'd1234));
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(0, 5) == 0) pwm_in = ~pwm_in;
            sense_mv   = 13'($urandom_range(0, 1100));
            if ($urandom_range(0, 3) != 0) sense_mv = 13'($urandom_range(0, 300));
            limit_mv   = 13'($urandom_range(0, 1500));
            limit_open = ($urandom_range(0, 7) == 0);
            vmain_mv   = 13'($urandom_range(0, 9) == 0 ? $urandom_range(4100, 4700) : 5000);
            vaux_mv    = 13'($urandom_range(0, 9) == 0 ? $urandom_range(2700, 3100) : 3300);
            step("R4 random");
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule